// File: doc/BRIEF.md
# Post-Reset Write-Lockout Serial Register Target

This block is the device side of a serial configuration link. It is a small register file behind an SPI slave port. After its active-low reset pin goes high again, it ignores every register write until an internal delay counter has run for 2^LOCK_W cycles of its own clock. The default LOCK_W of 20 gives about 105 ms at a 10 MHz internal clock. If that clock is at the slow end of a ±30 % tolerance, the wait is about 150 ms. Dropped writes are not flagged on the serial port. The `ready` output is the only sign that the lockout has ended.

The serial lines are sampled by the internal clock through synchronisers and decoded there. A frame is 24 bits, most significant bit first, in SPI mode 0:
- bit 23 selects the direction (1 = read, 0 = write),
- bits 22..8 carry the address,
- bits 7..0 carry the data.

Reads work at any time. On a read, data out shifts the addressed register during the final eight bit slots. If the device powers up with reset held high and never pulsed, there is no lockout and writes take effect at once. A host sequencer therefore has to wait out the lockout after each reset pulse before it programs the registers.

Top module: `spi_lockout_regs`

## Requirements
- R1: While `rst_n` is low, `ready` is low and every register returns to its default. The default of register i is (29*i + 53) mod 256.
- R2: After `rst_n` rises, `ready` stays low for at least 2^LOCK_W internal clock cycles. It is high no later than 2^LOCK_W + 4 cycles after the rise, and it stays high until the next reset.
- R3: A write frame that completes while `ready` is low changes no register.
- R4: A write frame that completes while `ready` is high stores its data bits 7..0 at its address. Later reads return that value.
- R5: After power-up with `rst_n` held high and no reset pulse, `ready` is high and writes take effect at once.
- R6: A frame is 24 bits, MSB first, captured on rising serial-clock edges while chip select is low. Bit 23 = 1 marks a read, bits 22..8 are the address and bits 7..0 are the data. On a read, data out presents register bits 7..0, MSB first, after each falling edge that follows bit 16, and the frame's data bits are ignored.
- R7: Addresses at or above NUM_REGS hold no storage. Writes to them change no register, and reads from them return 0.
- R8: A frame in which chip select rises before the 24th bit changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal state-machine clock |
| rst_n | input | 1 | Active-low reset; its rising edge starts the lockout |
| spi_csn | input | 1 | Active-low chip select |
| spi_sck | input | 1 | Serial clock, idle low |
| spi_mosi | input | 1 | Serial data into the block |
| spi_miso | output | 1 | Serial data out of the block, registered |
| ready | output | 1 | High when register writes are accepted |

## Verification
The assertions assume that the serial lines are slow compared with the internal clock. Each serial-clock half period must last several internal cycles so that no edge is lost in the synchronisers. The serial clock must also be low when chip select falls, and chip select must stay high for a few cycles between frames. The bench drives its serial master with six internal cycles per half period. It waits three half periods around each chip-select change, which keeps every frame inside these limits. Reset pulses last many cycles, so the synchronised reset is always seen.

// File: rtl/spilk_pkg.sv
package spilk_pkg;
  // power-on content of register idx (caller truncates to the data width)
  function automatic logic [31:0] reg_default(input int idx);
    return 32'(idx * 29 + 53);
  endfunction
endpackage

// File: rtl/spilk_sync.sv
module spilk_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_pin,
  input  logic csn_pin,
  input  logic sck_pin,
  input  logic mosi_pin,
  output logic rst,
  output logic csn_s,
  output logic sck_rise,
  output logic sck_fall,
  output logic mosi_s
);
  localparam int LINES = 4;
  logic [LINES-1:0] pipe [STAGES];
  logic             sck_d = 1'b0;

  initial begin
    for (int s = 0; s < STAGES; s++) pipe[s] = 4'b0011;
  end

  always_ff @(posedge clk) begin
    for (int s = 0; s < STAGES; s++) begin
      if (s == 0) pipe[s] <= {mosi_pin, sck_pin, csn_pin, rst_n_pin};
      else        pipe[s] <= pipe[s-1];
    end
    sck_d <= pipe[STAGES-1][2];
  end

  assign rst      = ~pipe[STAGES-1][0];
  assign csn_s    = pipe[STAGES-1][1];
  assign sck_rise = pipe[STAGES-1][2] & ~sck_d;
  assign sck_fall = ~pipe[STAGES-1][2] & sck_d;
  assign mosi_s   = pipe[STAGES-1][3];
endmodule

// File: rtl/spilk_lockout.sv
module spilk_lockout #(
  parameter int LOCK_W = 20
) (
  input  logic clk,
  input  logic rst,
  output logic ready
);
  logic [LOCK_W-1:0] cnt   = '0;
  logic              armed = 1'b0;
  logic              rdy_q = 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b1;
      cnt   <= '0;
      rdy_q <= 1'b0;
    end else if (armed) begin
      if (&cnt) begin
        armed <= 1'b0;
        rdy_q <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign ready = rdy_q;

  AST_RESET_CLEARS_READY: assert property (@(posedge clk) rst |=> !ready); // R1
  AST_READY_STICKY: assert property (@(posedge clk) disable iff (rst) ready |=> ready); // R2
  AST_NO_EARLY_READY: assert property (@(posedge clk) disable iff (rst) (armed && !(&cnt)) |=> !ready); // R2
endmodule

// File: rtl/spilk_shift.sv
module spilk_shift #(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              csn_s,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic              mosi_s,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              wr_req,
  output logic              miso
);
  localparam int FRAME = 1 + ADDR_W + DATA_W;
  localparam int HDR   = 1 + ADDR_W;
  localparam int CW    = $clog2(FRAME + 1);
  localparam logic [CW-1:0] FRAME_C = CW'(FRAME);
  localparam logic [CW-1:0] LAST_C  = CW'(FRAME - 1);
  localparam logic [CW-1:0] HDR_C   = CW'(HDR);

  logic [FRAME-1:0]  sh_in  = '0;
  logic [DATA_W-1:0] sh_out = '0;
  logic [CW-1:0]     bits   = '0;
  logic              req_q  = 1'b0;

  always_ff @(posedge clk) begin
    if (rst || csn_s) begin
      bits   <= '0;
      req_q  <= 1'b0;
      sh_out <= '0;
    end else begin
      req_q <= 1'b0;
      if (sck_rise && bits < FRAME_C) begin
        sh_in <= {sh_in[FRAME-2:0], mosi_s};
        bits  <= bits + 1'b1;
        if (bits == LAST_C && !sh_in[FRAME-2]) req_q <= 1'b1;
      end
      if (sck_fall) begin
        if (bits == HDR_C && sh_in[HDR-1]) sh_out <= rd_data;
        else                               sh_out <= sh_out << 1;
      end
    end
  end

  assign addr    = (bits == FRAME_C) ? sh_in[FRAME-2 -: ADDR_W] : sh_in[ADDR_W-1:0];
  assign wr_data = sh_in[DATA_W-1:0];
  assign wr_req  = req_q;
  assign miso    = sh_out[DATA_W-1];

  AST_BITS_IN_FRAME: assert property (@(posedge clk) disable iff (rst) bits <= FRAME_C); // R6
  AST_WRITE_NEEDS_FULL_FRAME: assert property (@(posedge clk) disable iff (rst) wr_req |-> bits == FRAME_C); // R8
  AST_MISO_QUIET_IDLE: assert property (@(posedge clk) disable iff (rst) csn_s |=> !miso); // R6
endmodule

// File: rtl/spilk_regfile.sv
module spilk_regfile #(
  parameter int NUM_REGS = 16,
  parameter int ADDR_W   = 15,
  parameter int DATA_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              allow,
  input  logic              wr_req,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam logic [ADDR_W-1:0] NUM_C = ADDR_W'(NUM_REGS);

  function automatic logic [NUM_REGS-1:0][DATA_W-1:0] defaults();
    logic [NUM_REGS-1:0][DATA_W-1:0] v;
    for (int i = 0; i < NUM_REGS; i++) v[i] = DATA_W'(spilk_pkg::reg_default(i));
    return v;
  endfunction

  logic [NUM_REGS-1:0][DATA_W-1:0] regs = defaults();
  logic [NUM_REGS-1:0][DATA_W-1:0] dflt;
  logic                            in_range;
  logic [IDX_W-1:0]                idx;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_dflt
    assign dflt[g] = DATA_W'(spilk_pkg::reg_default(g));
  end

  assign in_range = addr < NUM_C;
  assign idx      = addr[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (rst)                            regs      <= dflt;
    else if (wr_req && allow && in_range) regs[idx] <= wr_data;
  end

  assign rd_data = in_range ? regs[idx] : '0;

  AST_LOCKED_WRITE_DROPPED: assert property (@(posedge clk) disable iff (rst) (wr_req && !allow) |=> $stable(regs)); // R3
  AST_OUT_OF_RANGE_DROPPED: assert property (@(posedge clk) disable iff (rst) (wr_req && !in_range) |=> $stable(regs)); // R7
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst) !wr_req |=> $stable(regs)); // R4
endmodule

// File: rtl/spi_lockout_regs.sv
module spi_lockout_regs #(
  parameter int LOCK_W      = 20,
  parameter int NUM_REGS    = 16,
  parameter int ADDR_W      = 15,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_csn,
  input  logic spi_sck,
  input  logic spi_mosi,
  output logic spi_miso,
  output logic ready
);
  logic              rst, csn_s, sck_rise, sck_fall, mosi_s, wr_req;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] wr_data, rd_data;

  spilk_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n_pin(rst_n), .csn_pin(spi_csn), .sck_pin(spi_sck),
    .mosi_pin(spi_mosi), .rst(rst), .csn_s(csn_s), .sck_rise(sck_rise),
    .sck_fall(sck_fall), .mosi_s(mosi_s)
  );

  spilk_lockout #(.LOCK_W(LOCK_W)) u_lock (
    .clk(clk), .rst(rst), .ready(ready)
  );

  spilk_shift #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst(rst), .csn_s(csn_s), .sck_rise(sck_rise), .sck_fall(sck_fall),
    .mosi_s(mosi_s), .rd_data(rd_data), .addr(addr), .wr_data(wr_data),
    .wr_req(wr_req), .miso(spi_miso)
  );

  spilk_regfile #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .allow(ready), .wr_req(wr_req), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data)
  );
endmodule

// File: tb/spi_lockout_regs_test.sv
module spi_lockout_regs_test;
  localparam int LOCK_W = 14;
  localparam int NREG   = 16;
  localparam int HALF   = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b1, csn = 1'b1, sck = 1'b0, mosi = 1'b0;
  logic miso, ready;
  int   tests = 0, fails = 0, cyc = 0;

  spi_lockout_regs #(.LOCK_W(LOCK_W), .NUM_REGS(NREG)) uut (
    .clk(clk), .rst_n(rst_n), .spi_csn(csn), .spi_sck(sck),
    .spi_mosi(mosi), .spi_miso(miso), .ready(ready)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] dflt(input int i);
    return 8'((i * 29 + 53) % 256);
  endfunction

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input logic ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic rd, input int addr, input int data, input int nbits,
                      output logic [7:0] q);
    logic [23:0] w;
    w = {rd, addr[14:0], data[7:0]};
    q = '0;
    csn = 1'b0;
    tick(3 * HALF);
    for (int b = 23; b >= 24 - nbits; b--) begin
      mosi = w[b];
      tick(HALF);
      if (b < 8) q[b] = miso;
      sck = 1'b1;
      tick(HALF);
      sck = 1'b0;
    end
    tick(3 * HALF);
    csn = 1'b1;
    tick(3 * HALF);
  endtask

  task automatic wr(input int a, input int d);
    logic [7:0] q;
    xfer(1'b0, a, d, 24, q);
  endtask

  task automatic rd_check(input int a, input int exp, input string req);
    logic [7:0] q;
    xfer(1'b1, a, 8'h5A, 24, q);
    check(q == 8'(exp), req, q, exp);
  endtask

  initial begin
    tick(1);
    repeat (240000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int t0;
    tick(5);
    // R5: no reset pulse since power-up
    check(ready == 1'b1, "R5 ready at power-up", ready, 1);
    rd_check(3, dflt(3), "R5 power-up default");
    wr(3, 8'hA5);
    rd_check(3, 8'hA5, "R5 write without reset pulse");

    // R1: reset clears registers and ready
    rst_n = 1'b0;
    tick(10);
    check(ready == 1'b0, "R1 ready low in reset", ready, 0);
    rst_n = 1'b1;
    t0 = cyc;

    // R3: writes while locked are dropped; R6 reads allowed while locked
    for (int i = 0; i < 4; i++) wr(i, ~dflt(i));
    for (int i = 0; i < NREG; i++) rd_check(i, dflt(i), "R1 R3 default after locked write");
    check(ready == 1'b0, "R2 still locked", ready, 0);

    // R2: lockout length
    while (cyc - t0 < (1 << LOCK_W)) tick(1);
    check(ready == 1'b0, "R2 ready low at 2^N", ready, 0);
    while (cyc - t0 < (1 << LOCK_W) + 4) tick(1);
    check(ready == 1'b1, "R2 ready high by 2^N+4", ready, 1);

    // R4: full sweep write and readback
    for (int i = 0; i < NREG; i++) wr(i, (i * 7 + 17) ^ 8'hC3);
    for (int i = 0; i < NREG; i++) rd_check(i, 8'((i * 7 + 17) ^ 8'hC3), "R4 readback");
    check(ready == 1'b1, "R2 ready stays high", ready, 1);

    // R7: out-of-range addresses
    wr(NREG, 8'h11);
    wr(NREG + 1, 8'h22);
    wr(15'h7FFF, 8'h33);
    rd_check(NREG, 0, "R7 out-of-range read");
    rd_check(15'h7FFF, 0, "R7 top address read");
    rd_check(0, 8'((0 * 7 + 17) ^ 8'hC3), "R7 no alias reg0");
    rd_check(1, 8'((1 * 7 + 17) ^ 8'hC3), "R7 no alias reg1");

    // R8: aborted frames
    begin
      logic [7:0] q;
      xfer(1'b0, 5, 8'h00, 20, q);
      xfer(1'b0, 6, 8'h00, 23, q);
    end
    rd_check(5, 8'((5 * 7 + 17) ^ 8'hC3), "R8 short frame ignored");
    rd_check(6, 8'((6 * 7 + 17) ^ 8'hC3), "R8 23-bit frame ignored");

    // R6: read frame data bits do not write
    rd_check(7, 8'((7 * 7 + 17) ^ 8'hC3), "R6 read leaves register");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule